// File: doc/BRIEF.md
# Operating-Mode and Amplifier-Bias Sequencer

This block turns the chip-level enable pin and a three-bit operating-mode field into a set of power-domain enables. The domains are the reference oscillator, the frequency synthesizer (VCO and LO generation), the receive path, the transmit path and two reference clock buffers. Every enable is registered, so each one changes exactly one clock after the inputs that control it.

When transmit is entered, the block also raises a bias enable for an external power amplifier. It does this only after a programmable hold-off, counted in steps of a slow periodic tick. Two delay codes mean no hold-off at all.

A register bit can keep the amplifier bias on while the chip sits in any powered mode other than transmit. The mode field and the other control bits come from a register bank that survives shutdown; this block only decodes them.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `en_pin` is low, every output is 0 one cycle later, whatever the mode field, the keep-on bit or the clock-buffer bit hold.
- R2: With `en_pin` high and `mode_sel` = 3'b000 (clock-out only), only `osc_en_o` and `clkout1_en_o` among the domain enables are 1.
- R3: With `en_pin` high, `mode_sel` = 3'b001 (standby) and every code from 3'b100 to 3'b111 give `osc_en_o` = `synth_en_o` = 1 and `rx_en_o` = `tx_en_o` = 0.
- R4: With `en_pin` high and `mode_sel` = 3'b010 (receive), `osc_en_o`, `synth_en_o` and `rx_en_o` are 1 and `tx_en_o` is 0.
- R5: With `en_pin` high and `mode_sel` = 3'b011 (transmit), `osc_en_o`, `synth_en_o` and `tx_en_o` are 1 and `rx_en_o` is 0.
- R6: `clkout1_en_o` equals `en_pin` delayed by one cycle, in every mode.
- R7: `clkout2_en_o` equals `clkout2_bit AND en_pin` delayed by one cycle.
- R8: With `pa_dly_code` of 4'd0 or 4'd1, `pa_bias_o` is 1 on the first output cycle of transmit.
- R9: With `pa_dly_code` = c ≥ 2, `pa_bias_o` stays 0 in transmit until (c−1)·TICKS_PER_STEP `tick` pulses have been sampled after the entry cycle, and goes to 1 one cycle after the edge at which that count is reached.
- R10: The tick count restarts from zero on every entry into transmit. A partial count from an earlier transmit interval is never reused.
- R11: On the first output cycle after leaving transmit, `pa_bias_o` is 0 unless `pa_keep_on` is 1.
- R12: In clock-out, standby and receive (with `en_pin` high), `pa_bias_o` follows `pa_keep_on` one cycle later.
- R13: A synchronous active-high `rst` forces every output to 0 and clears the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Chip enable pin; low means shutdown |
| mode_sel | input | 3 | Operating-mode field |
| pa_dly_code | input | DLY_W | Amplifier-bias hold-off code |
| pa_keep_on | input | 1 | Keep amplifier bias on outside transmit |
| clkout2_bit | input | 1 | Secondary clock buffer enable bit |
| tick | input | 1 | One-cycle pulse per delay sub-step |
| osc_en_o | output | 1 | Reference oscillator enable |
| synth_en_o | output | 1 | Synthesizer / VCO / LO enable |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| clkout1_en_o | output | 1 | Primary clock buffer enable |
| clkout2_en_o | output | 1 | Secondary clock buffer enable |
| pa_bias_o | output | 1 | External amplifier bias enable |

## Verification
The bench builds the block with DLY_W = 4 and TICKS_PER_STEP = 2, so each delay code costs two tick pulses. With that setting, an off-by-one between code and step, or between ticks and steps, shows up as a distinct cycle error. The tick pulses arrive every third clock, so counting clocks instead of ticks would also be exposed.

All sixteen delay codes are walked through to completion, including the longest hold-off of 28 ticks. Transmit is abandoned part-way and re-entered to expose a count that is not restarted. The keep-on bit is toggled across every mode, including shutdown.

// File: rtl/pms_pkg.sv
package pms_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MF_CLKOUT = 3'b000;
  localparam logic [MODE_W-1:0] MF_STBY   = 3'b001;
  localparam logic [MODE_W-1:0] MF_RX     = 3'b010;
  localparam logic [MODE_W-1:0] MF_TX     = 3'b011;

  typedef enum logic [2:0] {
    OP_SHUT,
    OP_CLKO,
    OP_STBY,
    OP_RX,
    OP_TX
  } op_e;

  typedef struct packed {
    logic osc;
    logic synth;
    logic rx;
    logic tx;
  } dom_t;

endpackage

// File: rtl/pms_mode_decode.sv
module pms_mode_decode
  import pms_pkg::*;
(
  input  logic              en_pin,
  input  logic [MODE_W-1:0] mode_sel,
  output op_e               op,
  output dom_t              dom
);

  always_comb begin
    if (!en_pin) begin
      op = OP_SHUT;
    end else begin
      case (mode_sel)
        MF_CLKOUT: op = OP_CLKO;
        MF_RX:     op = OP_RX;
        MF_TX:     op = OP_TX;
        default:   op = OP_STBY;   // 001 and all unused codes
      endcase
    end
  end

  always_comb begin
    dom = '0;
    case (op)
      OP_CLKO: dom.osc = 1'b1;
      OP_STBY: begin
        dom.osc   = 1'b1;
        dom.synth = 1'b1;
      end
      OP_RX: begin
        dom.osc   = 1'b1;
        dom.synth = 1'b1;
        dom.rx    = 1'b1;
      end
      OP_TX: begin
        dom.osc   = 1'b1;
        dom.synth = 1'b1;
        dom.tx    = 1'b1;
      end
      default: dom = '0;
    endcase
  end

endmodule

// File: rtl/pms_pa_delay.sv
module pms_pa_delay #(
  parameter int DLY_W          = 4,
  parameter int TICKS_PER_STEP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_tx,
  input  logic             tick,
  input  logic [DLY_W-1:0] code,
  output logic             reached
);

  localparam int MAX_TICKS = ((1 << DLY_W) - 2) * TICKS_PER_STEP;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1) < 1 ? 1 : $clog2(MAX_TICKS + 1);

  logic             in_tx_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  // codes 0 and 1 both mean no hold-off; each code above adds one step
  always_comb begin
    if (code < DLY_W'(2))
      target = '0;
    else
      target = CNT_W'(code - DLY_W'(1)) * CNT_W'(TICKS_PER_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_tx_q <= 1'b0;
      cnt     <= '0;
    end else begin
      in_tx_q <= in_tx;
      if (!in_tx || !in_tx_q)
        cnt <= '0;
      else if (tick && (cnt < target))
        cnt <= cnt + CNT_W'(1);
    end
  end

  assign reached = (target == '0) || (in_tx_q && (cnt >= target));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int DLY_W          = 4,
  parameter int TICKS_PER_STEP = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_pin,
  input  logic [2:0]       mode_sel,
  input  logic [DLY_W-1:0] pa_dly_code,
  input  logic             pa_keep_on,
  input  logic             clkout2_bit,
  input  logic             tick,
  output logic             osc_en_o,
  output logic             synth_en_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             clkout1_en_o,
  output logic             clkout2_en_o,
  output logic             pa_bias_o
);

  op_e  op;
  dom_t dom;
  logic cur_tx;
  logic pa_reached;
  logic pa_next;

  pms_mode_decode u_dec (
    .en_pin   (en_pin),
    .mode_sel (mode_sel),
    .op       (op),
    .dom      (dom)
  );

  assign cur_tx = (op == OP_TX);

  pms_pa_delay #(
    .DLY_W          (DLY_W),
    .TICKS_PER_STEP (TICKS_PER_STEP)
  ) u_dly (
    .clk     (clk),
    .rst     (rst),
    .in_tx   (cur_tx),
    .tick    (tick),
    .code    (pa_dly_code),
    .reached (pa_reached)
  );

  always_comb begin
    if (cur_tx)
      pa_next = pa_reached;
    else if (op == OP_SHUT)
      pa_next = 1'b0;
    else
      pa_next = pa_keep_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en_o     <= 1'b0;
      synth_en_o   <= 1'b0;
      rx_en_o      <= 1'b0;
      tx_en_o      <= 1'b0;
      clkout1_en_o <= 1'b0;
      clkout2_en_o <= 1'b0;
      pa_bias_o    <= 1'b0;
    end else begin
      osc_en_o     <= dom.osc;
      synth_en_o   <= dom.synth;
      rx_en_o      <= dom.rx;
      tx_en_o      <= dom.tx;
      clkout1_en_o <= en_pin;
      clkout2_en_o <= en_pin & clkout2_bit;
      pa_bias_o    <= pa_next;
    end
  end

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en_pin,
  input logic [2:0]       mode_sel,
  input logic [DLY_W-1:0] pa_dly_code,
  input logic             pa_keep_on,
  input logic             osc_en_o,
  input logic             synth_en_o,
  input logic             rx_en_o,
  input logic             tx_en_o,
  input logic             clkout1_en_o,
  input logic             clkout2_en_o,
  input logic             pa_bias_o
);

  assert_shutdown_all_off_R1: assert property (@(posedge clk) disable iff (rst)
    !en_pin |=> !(osc_en_o || synth_en_o || rx_en_o || tx_en_o ||
                  clkout1_en_o || clkout2_en_o || pa_bias_o));

  assert_path_needs_synth_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_en_o || tx_en_o) |-> (synth_en_o && osc_en_o && !(rx_en_o && tx_en_o)));

  assert_clkout1_on_R6: assert property (@(posedge clk) disable iff (rst)
    en_pin |=> clkout1_en_o);

  assert_clkout2_gated_R7: assert property (@(posedge clk) disable iff (rst)
    clkout2_en_o |-> clkout1_en_o);

  assert_tx_entry_holds_off_R9: assert property (@(posedge clk) disable iff (rst)
    (en_pin && mode_sel == 3'b011 && !tx_en_o && pa_dly_code > DLY_W'(1)) |=> !pa_bias_o);

  assert_tx_entry_immediate_R8: assert property (@(posedge clk) disable iff (rst)
    (en_pin && mode_sel == 3'b011 && pa_dly_code <= DLY_W'(1)) |=> pa_bias_o);

  assert_bias_outside_tx_R11: assert property (@(posedge clk) disable iff (rst)
    (pa_bias_o && !tx_en_o) |-> $past(pa_keep_on));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.DLY_W(DLY_W)) u_chk (.*);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;

  localparam int DLY_W = 4;
  localparam int TPS   = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en_pin = 1'b0;
  logic [2:0]       mode_sel = 3'b000;
  logic [DLY_W-1:0] pa_dly_code = 4'd3;
  logic             pa_keep_on = 1'b0;
  logic             clkout2_bit = 1'b0;
  logic             tick = 1'b0;
  logic osc_en_o, synth_en_o, rx_en_o, tx_en_o, clkout1_en_o, clkout2_en_o, pa_bias_o;

  always #4 clk = ~clk;

  pwr_mode_seq #(.DLY_W(DLY_W), .TICKS_PER_STEP(TPS)) uut (
    .clk(clk), .rst(rst), .en_pin(en_pin), .mode_sel(mode_sel),
    .pa_dly_code(pa_dly_code), .pa_keep_on(pa_keep_on),
    .clkout2_bit(clkout2_bit), .tick(tick),
    .osc_en_o(osc_en_o), .synth_en_o(synth_en_o), .rx_en_o(rx_en_o),
    .tx_en_o(tx_en_o), .clkout1_en_o(clkout1_en_o),
    .clkout2_en_o(clkout2_en_o), .pa_bias_o(pa_bias_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R13";
  bit    auto_tick = 1'b1;

  // behavioural model state
  bit m_prev_tx = 0;
  int m_ticks   = 0;
  bit e_osc, e_syn, e_rx, e_tx, e_c1, e_c2, e_pa;

  task automatic cmp(string name, logic got, bit exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, name, cyc, got, exp);
    end
  endtask

  task automatic model();
    bit cur_tx;
    int target;
    cur_tx = en_pin && (mode_sel == 3'b011);
    target = (pa_dly_code < 2) ? 0 : (int'(pa_dly_code) - 1) * TPS;
    if (rst) begin
      {e_osc, e_syn, e_rx, e_tx, e_c1, e_c2, e_pa} = '0;
      m_prev_tx = 0;
      m_ticks   = 0;
    end else begin
      e_osc = en_pin;
      e_syn = en_pin && (mode_sel != 3'b000);
      e_rx  = en_pin && (mode_sel == 3'b010);
      e_tx  = cur_tx;
      e_c1  = en_pin;
      e_c2  = en_pin && clkout2_bit;
      if (cur_tx) begin
        if (!m_prev_tx) begin
          m_ticks = 0;
          e_pa = (target == 0);
        end else begin
          e_pa = (m_ticks >= target);
          if (tick) m_ticks++;
        end
      end else begin
        e_pa    = en_pin && pa_keep_on;
        m_ticks = 0;
      end
      m_prev_tx = cur_tx;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      if (auto_tick) tick = (cyc % 3 == 0);
      model();
      @(negedge clk);
      cyc++;
      cmp("osc_en", osc_en_o, e_osc);
      cmp("synth_en", synth_en_o, e_syn);
      cmp("rx_en", rx_en_o, e_rx);
      cmp("tx_en", tx_en_o, e_tx);
      cmp("clkout1_en", clkout1_en_o, e_c1);
      cmp("clkout2_en", clkout2_en_o, e_c2);
      cmp("pa_bias", pa_bias_o, e_pa);
    end
  endtask

  task automatic set_mode(bit en, logic [2:0] m);
    en_pin   = en;
    mode_sel = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R13: reset holds every output at zero
    tag = "R13";
    en_pin = 1'b1; mode_sel = 3'b011; pa_keep_on = 1'b1; clkout2_bit = 1'b1;
    pa_dly_code = 4'd0;
    @(negedge clk);
    run(3);
    rst = 1'b0;

    // R1: shutdown with every mode code and keep-on / clock bits set
    tag = "R1";
    for (int m = 0; m < 8; m++) begin
      set_mode(1'b0, 3'(m));
      run(2);
    end

    // R2: clock-out only
    tag = "R2";
    pa_keep_on = 1'b0; clkout2_bit = 1'b0;
    set_mode(1'b1, 3'b000); run(3);

    // R3: standby and the unused codes
    tag = "R3";
    set_mode(1'b1, 3'b001); run(2);
    for (int m = 4; m < 8; m++) begin
      set_mode(1'b1, 3'(m)); run(2);
    end

    // R4 / R5
    tag = "R4"; set_mode(1'b1, 3'b010); run(3);
    tag = "R5"; pa_dly_code = 4'd0; set_mode(1'b1, 3'b011); run(3);

    // R6: enable toggles while the mode stays put
    tag = "R6";
    set_mode(1'b0, 3'b010); run(1);
    set_mode(1'b1, 3'b010); run(1);
    set_mode(1'b0, 3'b000); run(2);
    set_mode(1'b1, 3'b000); run(2);

    // R7: secondary clock buffer in each mode, forced off in shutdown
    tag = "R7";
    for (int m = 0; m < 4; m++) begin
      clkout2_bit = 1'b1; set_mode(1'b1, 3'(m)); run(2);
      clkout2_bit = 1'b0; run(1);
      clkout2_bit = 1'b1; set_mode(1'b0, 3'(m)); run(2);
    end
    clkout2_bit = 1'b0;

    // R8: codes 0 and 1 give immediate bias
    tag = "R8";
    for (int c = 0; c < 2; c++) begin
      set_mode(1'b1, 3'b001); run(2);
      pa_dly_code = 4'(c);
      set_mode(1'b1, 3'b011); run(4);
    end

    // R9: every non-zero hold-off, run to completion
    tag = "R9";
    for (int c = 2; c < 16; c++) begin
      set_mode(1'b1, 3'b001); run(2);
      pa_dly_code = 4'(c);
      set_mode(1'b1, 3'b011);
      run((c - 1) * TPS * 3 + 6);
    end

    // R10: abandon transmit part-way, then re-enter
    tag = "R10";
    pa_dly_code = 4'd6;
    set_mode(1'b1, 3'b001); run(2);
    set_mode(1'b1, 3'b011); run(14);
    set_mode(1'b1, 3'b010); run(1);
    set_mode(1'b1, 3'b011); run(40);
    // steady tick every cycle across a re-entry
    auto_tick = 1'b0; tick = 1'b1;
    set_mode(1'b0, 3'b011); run(1);
    set_mode(1'b1, 3'b011); run(14);
    auto_tick = 1'b1;

    // R11: leaving transmit with and without keep-on
    tag = "R11";
    pa_dly_code = 4'd0;
    pa_keep_on = 1'b0; set_mode(1'b1, 3'b011); run(3);
    set_mode(1'b1, 3'b001); run(2);
    set_mode(1'b1, 3'b011); run(3);
    pa_keep_on = 1'b1; set_mode(1'b1, 3'b010); run(2);
    set_mode(1'b1, 3'b011); run(2);
    set_mode(1'b0, 3'b011); run(2);

    // R12: keep-on follows in non-transmit powered modes
    tag = "R12";
    for (int m = 0; m < 3; m++) begin
      set_mode(1'b1, 3'(m));
      pa_keep_on = 1'b1; run(2);
      pa_keep_on = 1'b0; run(2);
      pa_keep_on = 1'b1; run(1);
    end
    pa_keep_on = 1'b0;

    // R13: reset mid-transmit clears state
    tag = "R13";
    pa_dly_code = 4'd4;
    set_mode(1'b1, 3'b011); run(10);
    rst = 1'b1; run(2);
    rst = 1'b0; run(24);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule